// File: doc/BRIEF.md
# Multicycle Floating-Point Issue Interlock

This block sits in the decode stage of a five-stage integer pipeline that has been widened with three long execution paths: a four-stage pipelined FP adder, a seven-stage pipelined FP/integer multiplier and a 24-cycle divider that accepts only one operation at a time. Every cycle it looks at the instruction in decode (operation class, destination register and write enable, two optional source registers) and either lets it issue or holds it in place.

It keeps a countdown per architectural register giving the cycles left before a pending result can be forwarded. It keeps a reservation ring for the single register-file write port, a busy countdown for the divider, and a flag for each stall cause. Register operands are read only in decode, so write-after-read ordering needs no check. Write-after-write ordering does need one, because the three paths finish out of order. Loads and FP loads share the integer timing.

Top module: `fp_issue_interlock`

## Requirements
- R1: `issue` is high exactly when `id_valid` is high and none of the four stall flags is high. While `id_valid` is low, `issue` and all stall flags are low.
- R2: Class codes are 0 integer ALU, 1 load, 2 FP add, 3 FP multiply, 4 FP divide (5 to 7 act as integer). A consumer of a result can issue no sooner than L+1 cycles after its producer issued, with L = 0, 1, 3, 6, 24 for the five classes.
- R3: `stall_raw` is raised when an enabled source register still has a pending result that cannot yet be forwarded.
- R4: `stall_waw` is raised when a writing instruction's own result latency is shorter than the cycles still pending on its destination register. Example: an FP add behind an FP multiply to the same register issues four cycles after it.
- R5: `stall_div_busy` is raised for a divide while an earlier divide is less than 25 cycles old, so two divides issue at least 25 cycles apart.
- R6: Each writing instruction claims the write-port cycle that lies 3 (integer, load), 6 (FP add), 9 (FP multiply) or 26 (FP divide) cycles after issue. `stall_wb_port` is raised when that cycle is already claimed. An instruction with `id_dst_we` low claims nothing and never raises `stall_waw` or `stall_wb_port`.
- R7: After reset no register is pending, the divider is free and no write-port cycle is claimed, so the first instruction issues at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | An instruction occupies decode |
| id_class | input | 3 | Operation class code (R2) |
| id_dst | input | 6 | Destination register; bit 5 selects the FP file |
| id_dst_we | input | 1 | Instruction writes its destination |
| id_src_a | input | 6 | First source register |
| id_src_a_en | input | 1 | First source is used |
| id_src_b | input | 6 | Second source register |
| id_src_b_en | input | 1 | Second source is used |
| issue | output | 1 | Instruction leaves decode this cycle |
| stall_raw | output | 1 | Held by an operand not yet ready |
| stall_waw | output | 1 | Held to keep destination writes in order |
| stall_div_busy | output | 1 | Held because the divider is occupied |
| stall_wb_port | output | 1 | Held because its write-port cycle is taken |

## Verification
A wrong countdown value in the pending table shows up as a dependent instruction that issues one or more cycles early or late. That error is visible on `issue` and `stall_raw` in the first cycle a reader of that register reaches decode. A lost or misplaced write-port claim surfaces only when a later instruction targets that exact cycle, up to 26 cycles afterwards. For that reason the reference model compares all five outputs on every cycle of a long mixed stream and does not rely on the directed cases alone. A divider countdown that is too short lets a second divide through early, and the output shows this on the one cycle where the divide is accepted.

// File: rtl/fpi_pkg.sv
package fpi_pkg;

  typedef enum logic [2:0] {
    OP_INT  = 3'd0,
    OP_LOAD = 3'd1,
    OP_FADD = 3'd2,
    OP_FMUL = 3'd3,
    OP_FDIV = 3'd4
  } op_class_e;

  // Cycles between producer issue and the first cycle a consumer may issue, minus one.
  function automatic int unsigned result_latency(op_class_e c, int unsigned ld_lat,
                                                 int unsigned add_lat, int unsigned mul_lat,
                                                 int unsigned div_lat);
    case (c)
      OP_LOAD: return ld_lat;
      OP_FADD: return add_lat;
      OP_FMUL: return mul_lat;
      OP_FDIV: return div_lat;
      default: return 0;
    endcase
  endfunction

  // Cycles from issue to the register-file write: execute depth plus the MEM and WB stages.
  function automatic int unsigned wb_offset(op_class_e c, int unsigned add_st,
                                            int unsigned mul_st, int unsigned div_cyc,
                                            int unsigned post_st);
    case (c)
      OP_FADD: return add_st + post_st;
      OP_FMUL: return mul_st + post_st;
      OP_FDIV: return div_cyc + post_st;
      default: return 1 + post_st;
    endcase
  endfunction

endpackage

// File: rtl/fpi_pending_table.sv
module fpi_pending_table #(
  parameter int unsigned NREG  = 64,
  parameter int unsigned REG_W = 6,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] rd_a_idx,
  input  logic [REG_W-1:0] rd_b_idx,
  input  logic [REG_W-1:0] rd_d_idx,
  output logic [CNT_W-1:0] rd_a_cnt,
  output logic [CNT_W-1:0] rd_b_cnt,
  output logic [CNT_W-1:0] rd_d_cnt,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_idx,
  input  logic [CNT_W-1:0] set_val
);

  logic [CNT_W-1:0] cnt [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt[g] <= '0;
      end else if (set_en && set_idx == REG_W'(g)) begin
        cnt[g] <= set_val;
      end else if (cnt[g] != '0) begin
        cnt[g] <= cnt[g] - 1'b1;
      end
    end
  end

  assign rd_a_cnt = cnt[rd_a_idx];
  assign rd_b_cnt = cnt[rd_b_idx];
  assign rd_d_cnt = cnt[rd_d_idx];

  // A new claim lands exactly as written (R2).
  p_claim_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> cnt[$past(set_idx)] == $past(set_val));

  // An unclaimed, nonzero entry falls by one per cycle (R3).
  p_countdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en || set_idx != rd_a_idx) && rd_a_cnt != '0 |=> cnt[$past(rd_a_idx)] == $past(rd_a_cnt) - 1'b1);

endmodule

// File: rtl/fpi_wb_slots.sv
module fpi_wb_slots #(
  parameter int unsigned DEPTH  = 27,
  parameter int unsigned SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] probe_ofs,
  output logic              probe_busy,
  input  logic              take_en,
  input  logic [SLOT_W-1:0] take_ofs
);

  logic [DEPTH-1:0] slots;
  logic [DEPTH-1:0] take_mask;

  assign probe_busy = (int'(probe_ofs) < DEPTH) ? slots[probe_ofs] : 1'b0;
  assign take_mask  = take_en ? (DEPTH'(1) << take_ofs) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slots <= '0;
    else        slots <= (slots | take_mask) >> 1;
  end

  // A claim must target a free write cycle (R6).
  p_no_double_claim_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_en |-> !slots[take_ofs]);

  // The claimed cycle is still marked one cycle later, one step nearer (R6).
  p_claim_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_en && take_ofs != '0 |=> slots[$past(take_ofs) - 1'b1]);

endmodule

// File: rtl/fpi_div_busy.sv
module fpi_div_busy #(
  parameter int unsigned DIV_II = 25,
  parameter int unsigned DC_W   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle
);

  logic [DC_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left <= '0;
    else if (start)         left <= DC_W'(DIV_II - 1);
    else if (left != '0)    left <= left - 1'b1;
  end

  assign idle = (left == '0);

  // A divide starts only on a free divider (R5).
  p_start_when_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> idle);

  // Starting reloads the full occupancy window (R5).
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> left == DC_W'(DIV_II - 1));

endmodule

// File: rtl/fp_issue_interlock.sv
module fp_issue_interlock
  import fpi_pkg::*;
#(
  parameter int unsigned REG_W      = 6,
  parameter int unsigned LAT_LOAD   = 1,
  parameter int unsigned LAT_FADD   = 3,
  parameter int unsigned LAT_FMUL   = 6,
  parameter int unsigned LAT_FDIV   = 24,
  parameter int unsigned ADD_STAGES = 4,
  parameter int unsigned MUL_STAGES = 7,
  parameter int unsigned DIV_CYCLES = 24,
  parameter int unsigned POST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_valid,
  input  logic [2:0]       id_class,
  input  logic [REG_W-1:0] id_dst,
  input  logic             id_dst_we,
  input  logic [REG_W-1:0] id_src_a,
  input  logic             id_src_a_en,
  input  logic [REG_W-1:0] id_src_b,
  input  logic             id_src_b_en,
  output logic             issue,
  output logic             stall_raw,
  output logic             stall_waw,
  output logic             stall_div_busy,
  output logic             stall_wb_port
);

  localparam int unsigned NREG     = 1 << REG_W;
  localparam int unsigned LAT_M1   = (LAT_LOAD > LAT_FADD) ? LAT_LOAD : LAT_FADD;
  localparam int unsigned LAT_M2   = (LAT_FMUL > LAT_FDIV) ? LAT_FMUL : LAT_FDIV;
  localparam int unsigned MAX_LAT  = (LAT_M1 > LAT_M2) ? LAT_M1 : LAT_M2;
  localparam int unsigned CNT_W    = $clog2(MAX_LAT + 1);
  localparam int unsigned EX_M1    = (ADD_STAGES > MUL_STAGES) ? ADD_STAGES : MUL_STAGES;
  localparam int unsigned EX_MAX   = (EX_M1 > DIV_CYCLES) ? EX_M1 : DIV_CYCLES;
  localparam int unsigned WB_DEPTH = EX_MAX + POST_STAGES + 1;
  localparam int unsigned SLOT_W   = $clog2(WB_DEPTH);
  localparam int unsigned DIV_II   = DIV_CYCLES + 1;
  localparam int unsigned DC_W     = $clog2(DIV_II);

  op_class_e        cls;
  logic [CNT_W-1:0] lat;
  logic [SLOT_W-1:0] wb_ofs;
  logic [CNT_W-1:0] a_cnt, b_cnt, d_cnt;
  logic             slot_taken;
  logic             div_idle;
  logic             hz_raw_a, hz_raw_b;
  logic             claim_reg, claim_slot, div_start;

  always_comb begin
    cls    = op_class_e'(id_class);
    lat    = CNT_W'(result_latency(cls, LAT_LOAD, LAT_FADD, LAT_FMUL, LAT_FDIV));
    wb_ofs = SLOT_W'(wb_offset(cls, ADD_STAGES, MUL_STAGES, DIV_CYCLES, POST_STAGES));
  end

  fpi_pending_table #(.NREG(NREG), .REG_W(REG_W), .CNT_W(CNT_W)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (id_src_a),
    .rd_b_idx (id_src_b),
    .rd_d_idx (id_dst),
    .rd_a_cnt (a_cnt),
    .rd_b_cnt (b_cnt),
    .rd_d_cnt (d_cnt),
    .set_en   (claim_reg),
    .set_idx  (id_dst),
    .set_val  (lat)
  );

  fpi_wb_slots #(.DEPTH(WB_DEPTH), .SLOT_W(SLOT_W)) u_wb (
    .clk        (clk),
    .rst_n      (rst_n),
    .probe_ofs  (wb_ofs),
    .probe_busy (slot_taken),
    .take_en    (claim_slot),
    .take_ofs   (wb_ofs)
  );

  fpi_div_busy #(.DIV_II(DIV_II), .DC_W(DC_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .idle  (div_idle)
  );

  assign hz_raw_a       = id_src_a_en && (a_cnt != '0);
  assign hz_raw_b       = id_src_b_en && (b_cnt != '0);
  assign stall_raw      = id_valid && (hz_raw_a || hz_raw_b);
  assign stall_waw      = id_valid && id_dst_we && (d_cnt > lat);
  assign stall_div_busy = id_valid && (cls == OP_FDIV) && !div_idle;
  assign stall_wb_port  = id_valid && id_dst_we && slot_taken;
  assign issue          = id_valid && !(stall_raw || stall_waw || stall_div_busy || stall_wb_port);

  assign claim_reg  = issue && id_dst_we;
  assign claim_slot = issue && id_dst_we;
  assign div_start  = issue && (cls == OP_FDIV);

  // Idle decode raises nothing (R1).
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> !issue && !stall_raw && !stall_waw && !stall_div_busy && !stall_wb_port);

  // Issued operands are forwardable (R3).
  p_operands_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (!id_src_a_en || a_cnt == '0) && (!id_src_b_en || b_cnt == '0));

  // An issued writer never finishes ahead of the pending writer of its register (R4).
  p_write_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue && id_dst_we |-> d_cnt <= lat);

  // A non-writing instruction is never held for write ordering or the write port (R6).
  p_nowrite_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid && !id_dst_we |-> !stall_waw && !stall_wb_port);

endmodule

// File: tb/test_fp_issue_interlock.sv
module test_fp_issue_interlock;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       id_valid;
  logic [2:0] id_class;
  logic [5:0] id_dst, id_src_a, id_src_b;
  logic       id_dst_we, id_src_a_en, id_src_b_en;
  logic       issue, stall_raw, stall_waw, stall_div_busy, stall_wb_port;

  always #5 clk = ~clk;

  fp_issue_interlock i_fp_issue_interlock (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_class(id_class),
    .id_dst(id_dst), .id_dst_we(id_dst_we), .id_src_a(id_src_a), .id_src_a_en(id_src_a_en),
    .id_src_b(id_src_b), .id_src_b_en(id_src_b_en), .issue(issue), .stall_raw(stall_raw),
    .stall_waw(stall_waw), .stall_div_busy(stall_div_busy), .stall_wb_port(stall_wb_port)
  );

  int pend [64];
  int wbq  [40];
  int divc;
  int cyc;
  int n_cmp;
  int n_bad;
  bit done;

  function automatic int lat_of(int c);
    case (c) 1: return 1; 2: return 3; 3: return 6; 4: return 24; default: return 0; endcase
  endfunction

  function automatic int wb_of(int c);
    case (c) 2: return 6; 3: return 9; 4: return 26; default: return 3; endcase
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0b expected %0b", req, cyc, act, exp);
    end
  endtask

  task automatic gapchk(string req, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual gap %0d expected gap %0d", req, got, exp);
    end
  endtask

  task automatic model_clear();
    for (int r = 0; r < 64; r++) pend[r] = 0;
    for (int j = 0; j < 40; j++) wbq[j] = 0;
    divc = 0;
  endtask

  // One cycle: inputs are already driven after a falling edge.
  task automatic tick(output bit went);
    bit e_raw, e_waw, e_div, e_wb, e_iss;
    int c;
    #1;
    c     = int'(id_class);
    e_raw = id_valid && ((id_src_a_en && pend[id_src_a] > 0) || (id_src_b_en && pend[id_src_b] > 0));
    e_waw = id_valid && id_dst_we && (pend[id_dst] > lat_of(c));
    e_div = id_valid && (c == 4) && (divc > 0);
    e_wb  = id_valid && id_dst_we && (wbq[wb_of(c)] != 0);
    e_iss = id_valid && !(e_raw || e_waw || e_div || e_wb);
    chk("R1 issue", issue, e_iss);
    chk("R3 raw", stall_raw, e_raw);
    chk("R4 waw", stall_waw, e_waw);
    chk("R5 div", stall_div_busy, e_div);
    chk("R6 wb", stall_wb_port, e_wb);
    for (int r = 0; r < 64; r++) begin
      if (e_iss && id_dst_we && r == int'(id_dst)) pend[r] = lat_of(c);
      else if (pend[r] > 0) pend[r] = pend[r] - 1;
    end
    if (e_iss && id_dst_we) wbq[wb_of(c)] = 1;
    for (int j = 0; j < 39; j++) wbq[j] = wbq[j + 1];
    wbq[39] = 0;
    if (e_iss && c == 4) divc = 24;
    else if (divc > 0) divc = divc - 1;
    went = e_iss;
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(int n);
    bit w;
    id_valid = 1'b0;
    for (int i = 0; i < n; i++) tick(w);
  endtask

  task automatic send(int c, int d, bit we, int sa, bit ea, int sb, bit eb, output int t_iss);
    bit w;
    int tries;
    id_valid = 1'b1; id_class = 3'(c); id_dst = 6'(d); id_dst_we = we;
    id_src_a = 6'(sa); id_src_a_en = ea; id_src_b = 6'(sb); id_src_b_en = eb;
    tries = 0;
    w = 1'b0;
    while (!w && tries < 200) begin
      t_iss = cyc;
      tick(w);
      tries++;
    end
    id_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    if (!done && cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected under 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int t0, t1, t2, t3;
    bit w;
    done = 1'b0; cyc = 0; n_cmp = 0; n_bad = 0;
    model_clear();
    rst_n = 1'b0; id_valid = 1'b0; id_class = '0; id_dst = '0; id_dst_we = 1'b0;
    id_src_a = '0; id_src_a_en = 1'b0; id_src_b = '0; id_src_b_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7: first instruction after reset issues at once.
    id_valid = 1'b1; id_class = 3'd4; id_dst = 6'd40; id_dst_we = 1'b1;
    id_src_a = 6'd5; id_src_a_en = 1'b1; id_src_b = 6'd6; id_src_b_en = 1'b1;
    #1;
    chk("R7 reset issue", issue, 1'b1);
    chk("R7 reset raw", stall_raw, 1'b0);
    chk("R7 reset wb", stall_wb_port, 1'b0);
    chk("R7 reset div", stall_div_busy, 1'b0);
    tick(w);
    idle(30);

    // R2: producer-to-consumer spacing per class.
    send(0, 1, 1, 0, 0, 0, 0, t0); send(0, 2, 1, 1, 1, 0, 0, t1); gapchk("R2 int", t1 - t0, 1);
    idle(30);
    send(1, 3, 1, 0, 0, 0, 0, t0); send(0, 4, 1, 3, 1, 0, 0, t1); gapchk("R2 load", t1 - t0, 2);
    idle(30);
    send(2, 33, 1, 0, 0, 0, 0, t0); send(2, 34, 1, 0, 0, 33, 1, t1); gapchk("R2 fadd", t1 - t0, 4);
    idle(30);
    send(3, 35, 1, 0, 0, 0, 0, t0); send(2, 36, 1, 35, 1, 0, 0, t1); gapchk("R2 fmul", t1 - t0, 7);
    idle(30);
    send(4, 37, 1, 0, 0, 0, 0, t0); send(2, 38, 1, 37, 1, 0, 0, t1); gapchk("R2 fdiv", t1 - t0, 25);
    idle(30);
    // R5: back-to-back independent divides.
    send(4, 41, 1, 0, 0, 0, 0, t0); send(4, 42, 1, 0, 0, 0, 0, t1); gapchk("R5 div spacing", t1 - t0, 25);
    idle(30);
    // R4: add behind multiply to the same register.
    send(3, 40, 1, 0, 0, 0, 0, t0); send(2, 40, 1, 0, 0, 0, 0, t1); gapchk("R4 waw", t1 - t0, 4);
    idle(30);
    // R6: add aimed at the multiply's write cycle slips by one.
    send(3, 43, 1, 0, 0, 0, 0, t0); send(0, 10, 1, 0, 0, 0, 0, t1); send(0, 11, 1, 0, 0, 0, 0, t2);
    send(2, 44, 1, 0, 0, 0, 0, t3); gapchk("R6 port conflict", t3 - t0, 4);
    idle(30);
    // R6: a non-writing instruction behind a multiply to the same register is not held.
    send(3, 45, 1, 0, 0, 0, 0, t0); send(1, 45, 0, 0, 0, 0, 0, t1); gapchk("R6 no write", t1 - t0, 1);
    idle(30);

    // Mixed stream: every cycle compared against the model.
    for (int i = 0; i < 4000; i++) begin
      id_valid    = ($urandom % 10) < 8;
      id_class    = 3'($urandom % 5);
      id_dst      = 6'(($urandom % 2) * 32 + ($urandom % 6));
      id_dst_we   = ($urandom % 8) != 0;
      id_src_a    = 6'(($urandom % 2) * 32 + ($urandom % 6));
      id_src_a_en = $urandom % 2;
      id_src_b    = 6'(($urandom % 2) * 32 + ($urandom % 6));
      id_src_b_en = $urandom % 2;
      tick(w);
    end
    idle(5);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule